// File: doc/BRIEF.md
# Dual Segmented Shift Register with Bidirectional Taps

This block holds two independent 64-bit serial shift registers. Each register is split into four 16-stage segments. A tap sits after each segment. In shift mode the taps show the last bit of their segments, and the register behaves as one continuous 64-stage chain fed from its serial input. In load mode the first three taps turn round and become inputs. They feed the first stage of the following segment, while the serial input keeps feeding stage 1. All four segments then fill in parallel, so a complete 64-bit word goes in within 16 clocks instead of 64.

Each tap is modelled as separate `tap_in`, `tap_out` and `tap_oe` signals, and the pad-level three-state buffer lies outside the block. The last tap, after stage 64, is output-only. Every register has its own clock, serial input and write enable. The mode decoder has two named modes: `MODE_SHIFT`, taken when the write enable is 0, and `MODE_LOAD`, taken when it is 1. The mode follows the write enable combinationally in both directions (`MODE_SHIFT` to `MODE_LOAD` on a rise, and back on a fall), so there is no mode register and no transition delay. There is no reset. The contents are undefined until they have been loaded.

Top module: `tapped_shreg_dual`

## Requirements
- R1: Each register has 64 stages grouped as four 16-stage segments. On every rising clock edge, stage 1 captures the serial input.
- R2: With write enable at 0, every rising edge moves each stage's bit to the next stage. Stages 17, 33 and 49 take the bits of stages 16, 32 and 48, forming one continuous chain.
- R3: With write enable at 1, stages 17, 33 and 49 capture `tap_in[0]`, `tap_in[1]` and `tap_in[2]` on the rising edge, while every other stage shifts as in R2. Sixteen such clocks replace all 64 bits.
- R4: `tap_out[k]` carries the content of stage 16·(k+1), for k = 0..3.
- R5: While write enable is 1, all four `tap_oe` bits are 0 (high impedance).
- R6: While write enable is 0, all four `tap_oe` bits are 1.
- R7: `tap_in` has no effect on the contents while write enable is 0.
- R8: The two registers are independent. A register whose clock stays idle keeps its contents and tap values while the other register is clocked and written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_clk | input | 1 | Clock of register A, rising-edge active |
| a_din | input | 1 | Serial input of register A (stage 1) |
| a_wr_en | input | 1 | Register A mode: 1 load through taps, 0 shift |
| a_tap_in | input | NSEG-1 | Register A tap inputs feeding stages 17, 33, 49 in load mode |
| a_tap_out | output | NSEG | Register A tap values after stages 16, 32, 48, 64 |
| a_tap_oe | output | NSEG | Register A tap drive enables, 1 = drive |
| b_clk | input | 1 | Clock of register B, rising-edge active |
| b_din | input | 1 | Serial input of register B (stage 1) |
| b_wr_en | input | 1 | Register B mode: 1 load through taps, 0 shift |
| b_tap_in | input | NSEG-1 | Register B tap inputs feeding stages 17, 33, 49 in load mode |
| b_tap_out | output | NSEG | Register B tap values after stages 16, 32, 48, 64 |
| b_tap_oe | output | NSEG | Register B tap drive enables, 1 = drive |

## Verification
A wrong bit inside a segment stays hidden until it reaches that segment's tap. Because every stage is at most 15 positions from a tap, such an error shows on a tap output within 15 shift-mode clocks. A misrouted segment head is exposed even sooner: when the mode mux picks the wrong source, the error shows at the next tap within 16 clocks and then repeats at every later tap. A wrong enable decode shows on `tap_oe` in the same cycle the write enable changes. Cross-talk between the two registers shows as a change on the idle register's taps while only the other register is clocked.

// File: rtl/tsr_pkg.sv
package tsr_pkg;
    typedef enum logic {
        MODE_SHIFT = 1'b0,
        MODE_LOAD  = 1'b1
    } tsr_mode_e;
endpackage

// File: rtl/tsr_segment.sv
module tsr_segment #(
    parameter int LEN = 16
) (
    input  logic           clk,
    input  logic           head_d,
    output logic [LEN-1:0] bits
);
    // bits[0] is the first stage of the segment, bits[LEN-1] feeds the tap
    always_ff @(posedge clk) begin
        bits <= {bits[LEN-2:0], head_d};
    end

    logic primed = 1'b0;
    always_ff @(posedge clk) primed <= 1'b1;

    // R1 / R2 / R3: the head stage takes whatever the channel routes to it
    a_r1_head_capture: assert property (@(posedge clk) disable iff (!primed)
        bits[0] === $past(head_d));
    // R2: body of the segment moves one place per edge
    a_r2_body_shift: assert property (@(posedge clk) disable iff (!primed)
        bits[LEN-1:1] === $past(bits[LEN-2:0]));
endmodule

// File: rtl/tsr_mode_ctl.sv
module tsr_mode_ctl
    import tsr_pkg::*;
#(
    parameter int NSEG = 4
) (
    input  logic            clk,
    input  logic            wr_en,
    output logic            load_sel,
    output logic [NSEG-1:0] tap_oe
);
    tsr_mode_e mode;

    always_comb begin
        mode = wr_en ? MODE_LOAD : MODE_SHIFT;
    end

    always_comb begin
        unique case (mode)
            MODE_SHIFT: begin
                load_sel = 1'b0;
                tap_oe   = '1;
            end
            MODE_LOAD: begin
                load_sel = 1'b1;
                tap_oe   = '0;
            end
            default: begin
                load_sel = 1'b0;
                tap_oe   = '1;
            end
        endcase
    end

    a_r5_hiz_in_load: assert property (@(posedge clk)
        wr_en |-> (tap_oe == '0));
    a_r6_drive_in_shift: assert property (@(posedge clk)
        !wr_en |-> (tap_oe == '1));
endmodule

// File: rtl/tsr_channel.sv
module tsr_channel #(
    parameter int SEG_LEN = 16,
    parameter int NSEG    = 4
) (
    input  logic            clk,
    input  logic            din,
    input  logic            wr_en,
    input  logic [NSEG-2:0] tap_in,
    output logic [NSEG-1:0] tap_out,
    output logic [NSEG-1:0] tap_oe
);
    logic                          load_sel;
    logic [NSEG-1:0]               head;
    logic [NSEG-1:0][SEG_LEN-1:0]  seg_bits;

    tsr_mode_ctl #(.NSEG(NSEG)) ctl_i (
        .clk      (clk),
        .wr_en    (wr_en),
        .load_sel (load_sel),
        .tap_oe   (tap_oe)
    );

    logic primed = 1'b0;
    always_ff @(posedge clk) primed <= 1'b1;

    for (genvar k = 0; k < NSEG; k++) begin : g_seg
        if (k == 0) begin : g_first
            assign head[k] = din;
        end else begin : g_inner
            assign head[k] = load_sel ? tap_in[k-1] : seg_bits[k-1][SEG_LEN-1];

            // R3: in load mode the head stage takes the tap input
            a_r3_tap_load: assert property (@(posedge clk) disable iff (!primed)
                wr_en |=> (seg_bits[k][0] === $past(tap_in[k-1])));
            // R2 / R7: in shift mode the chain is continuous, tap input unused
            a_r7_chain_in_shift: assert property (@(posedge clk) disable iff (!primed)
                !wr_en |=> (seg_bits[k][0] === $past(seg_bits[k-1][SEG_LEN-1])));
        end

        tsr_segment #(.LEN(SEG_LEN)) seg_i (
            .clk    (clk),
            .head_d (head[k]),
            .bits   (seg_bits[k])
        );

        assign tap_out[k] = seg_bits[k][SEG_LEN-1];
    end
endmodule

// File: rtl/tapped_shreg_dual.sv
module tapped_shreg_dual #(
    parameter int SEG_LEN = 16,
    parameter int NSEG    = 4
) (
    input  logic            a_clk,
    input  logic            a_din,
    input  logic            a_wr_en,
    input  logic [NSEG-2:0] a_tap_in,
    output logic [NSEG-1:0] a_tap_out,
    output logic [NSEG-1:0] a_tap_oe,
    input  logic            b_clk,
    input  logic            b_din,
    input  logic            b_wr_en,
    input  logic [NSEG-2:0] b_tap_in,
    output logic [NSEG-1:0] b_tap_out,
    output logic [NSEG-1:0] b_tap_oe
);
    tsr_channel #(.SEG_LEN(SEG_LEN), .NSEG(NSEG)) ch_a_i (
        .clk     (a_clk),
        .din     (a_din),
        .wr_en   (a_wr_en),
        .tap_in  (a_tap_in),
        .tap_out (a_tap_out),
        .tap_oe  (a_tap_oe)
    );

    tsr_channel #(.SEG_LEN(SEG_LEN), .NSEG(NSEG)) ch_b_i (
        .clk     (b_clk),
        .din     (b_din),
        .wr_en   (b_wr_en),
        .tap_in  (b_tap_in),
        .tap_out (b_tap_out),
        .tap_oe  (b_tap_oe)
    );
endmodule

// File: tb/tapped_shreg_dual_tb_top.sv
module tapped_shreg_dual_tb_top;
    localparam int L = 16;
    localparam int N = 4;
    localparam int T = L * N;

    logic clk = 1'b0;
    always #10 clk = ~clk;
    logic b_run = 1'b0;
    logic b_clk;
    assign b_clk = clk & b_run;

    logic         a_din = 1'b0, a_wr_en = 1'b1;
    logic [N-2:0] a_tap_in = '0;
    logic [N-1:0] a_tap_out, a_tap_oe;
    logic         b_din = 1'b0, b_wr_en = 1'b0;
    logic [N-2:0] b_tap_in = '0;
    logic [N-1:0] b_tap_out, b_tap_oe;

    int checks = 0;
    int errors = 0;

    tapped_shreg_dual #(.SEG_LEN(L), .NSEG(N)) dut_i (
        .a_clk(clk), .a_din(a_din), .a_wr_en(a_wr_en), .a_tap_in(a_tap_in),
        .a_tap_out(a_tap_out), .a_tap_oe(a_tap_oe),
        .b_clk(b_clk), .b_din(b_din), .b_wr_en(b_wr_en), .b_tap_in(b_tap_in),
        .b_tap_out(b_tap_out), .b_tap_oe(b_tap_oe)
    );

    // Behavioural model: index 0 is stage 1, index T-1 is stage 64
    bit [T-1:0] am = '0, ak = '0, bm = '0, bk = '0;

    function automatic bit [T-1:0] step(bit [T-1:0] cur, bit d, bit we, bit [N-2:0] ti);
        bit [T-1:0] r;
        for (int s = T - 1; s >= 1; s--) begin
            if (we && (s % L == 0)) r[s] = ti[s / L - 1];
            else                    r[s] = cur[s - 1];
        end
        r[0] = d;
        return r;
    endfunction

    always @(posedge clk) begin
        am = step(am, a_din, a_wr_en, a_tap_in);
        ak = step(ak, 1'b1, a_wr_en, '1);
    end
    always @(posedge b_clk) begin
        bm = step(bm, b_din, b_wr_en, b_tap_in);
        bk = step(bk, 1'b1, b_wr_en, '1);
    end

    task automatic check_ch(string nm, logic we, logic [N-1:0] oe, logic [N-1:0] out,
                            bit [T-1:0] m, bit [T-1:0] k);
        logic [N-1:0] exp_oe;
        exp_oe = we ? '0 : '1;
        checks++;
        if (oe !== exp_oe) begin
            errors++;
            $display("FAIL %s %s tap_oe: got %b expected %b", nm, we ? "R5" : "R6", oe, exp_oe);
        end
        if (!we) begin
            for (int t = 0; t < N; t++) begin
                if (k[t * L + L - 1]) begin
                    checks++;
                    if (out[t] !== m[t * L + L - 1]) begin
                        errors++;
                        $display("FAIL %s R4 (contents per R1 R2 R3 R7 R8) tap %0d: got %b expected %b",
                                 nm, t, out[t], m[t * L + L - 1]);
                    end
                end
            end
        end
    endtask

    task automatic check_both();
        check_ch("A", a_wr_en, a_tap_oe, a_tap_out, am, ak);
        check_ch("B", b_wr_en, b_tap_oe, b_tap_out, bm, bk);
    endtask

    // one clock: inputs already driven, wait edge, check away from it
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        check_both();
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #5;
        // initial enables follow write enable (A in load, B in shift): R5 R6
        check_both();
        @(negedge clk);
        b_run   = 1'b1;
        b_wr_en = 1'b1;
        // R3: 16-clock parallel load on both registers, R1 stage 1 from din
        for (int i = 0; i < L; i++) begin
            a_din = 1'($urandom); a_tap_in = (N-1)'($urandom);
            b_din = 1'($urandom); b_tap_in = (N-1)'($urandom);
            tick();
        end
        // R2 R4 R7: shift mode with random tap_in that must be ignored
        a_wr_en = 1'b0; b_wr_en = 1'b0;
        for (int i = 0; i < 70; i++) begin
            a_din = 1'($urandom); a_tap_in = (N-1)'($urandom);
            b_din = 1'($urandom); b_tap_in = (N-1)'($urandom);
            tick();
        end
        // R8: B clock idle, A reloaded and shifted; B taps must hold
        b_run = 1'b0;
        b_din = 1'b1; b_tap_in = '1;
        for (int i = 0; i < 40; i++) begin
            a_wr_en = (i < L);
            a_din = 1'($urandom); a_tap_in = (N-1)'($urandom);
            tick();
        end
        // mixed mode changes, constant all-ones and all-zero patterns
        b_run = 1'b1;
        for (int i = 0; i < 80; i++) begin
            a_wr_en = ((i / 5) % 2) == 1;
            b_wr_en = ((i / 7) % 2) == 0;
            a_din = (i < 40); a_tap_in = (i < 40) ? '1 : '0;
            b_din = 1'($urandom); b_tap_in = (N-1)'($urandom);
            tick();
        end
        a_wr_en = 1'b0; b_wr_en = 1'b0;
        for (int i = 0; i < 20; i++) begin
            a_din = 1'($urandom); b_din = 1'($urandom);
            tick();
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule